// File: doc/BRIEF.md
# Trigger Word Capture and Serial Shifter

This block turns the hit flags of a row of detector channels into a trigger word and sends that word bit by bit to an external trigger system. A channel takes part only when three conditions hold: it is set to the anode-readout mode, a mask authorises it, and its inhibit is low. A hit on such a channel opens a validity window of `WIN_CYCLES` system-clock cycles. The default is 9200 cycles, about 115 µs at 80 MHz. A new hit inside the window starts it again. When the window runs out, the flag clears.

While the lock input is low, the shift register follows the flags on every cycle. Raising the lock freezes the last captured pattern. After that, each rising edge of the trigger clock moves the word one bit toward the serial output. The trigger clock comes from outside and is asynchronous, so it is synchronised into the system clock before its rising edges are detected. Channel 0 leaves first, and zeros follow the last bit. The word is either the full `N_CH` bits (27) or a short form of `SHORT_LEN` bits (18). The short form forces the upper channels to zero.

Top module: `trig_word_shifter`

## Requirements
- R1: After reset the serial output is 0 and a word read out before any hit is all zeros.
- R2: A hit on an eligible channel keeps that channel's flag high for exactly `WIN_CYCLES` cycles. A lock raised `WIN_CYCLES` cycles after the hit edge still captures the bit. One cycle later the bit is captured as 0.
- R3: A second hit during the window restarts the full `WIN_CYCLES` count from the second hit.
- R4: A channel contributes only if anode mode is 1, authorisation is 1 and inhibit is 0. Bit i of the word belongs to channel i.
- R5: If a channel becomes ineligible while its window is open, its flag clears on the next cycle and stays clear until a new hit.
- R6: While lock is high, new hits and flag changes do not alter the captured word.
- R7: With lock high, bit 0 is on the output at once. Each trigger-clock rising edge advances one bit, and the output changes at the third system-clock rising edge after the trigger clock rises.
- R8: With short mode set to 1, word bits `SHORT_LEN` and above are captured as 0. With short mode at 0, all `N_CH` bits are kept.
- R9: After the last word bit has been shifted out, the output carries zeros.
- R10: Trigger-clock edges while lock is low have no effect on the word captured at the next lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_i | input | N_CH | Per-channel hit pulses |
| anodic_i | input | N_CH | 1 = channel in anode-readout mode |
| auth_i | input | N_CH | 1 = channel authorised for the trigger word |
| inhibit_i | input | N_CH | 1 = channel barred from contributing |
| short_mode_i | input | 1 | 1 = short word of SHORT_LEN bits |
| lock_i | input | 1 | 1 = freeze captured word and allow shifting |
| tclk_i | input | 1 | Asynchronous trigger shift clock |
| tdata_o | output | 1 | Serial trigger word, channel 0 first |

## Verification
The hardest case to reach is the edge of the validity window. A lock raised exactly `WIN_CYCLES` cycles after the hit must capture the bit, and one cycle later it must not. The same boundary arises after a restart, where the count begins again from the second hit. The bench places each hit on a known edge and counts falling edges before raising the lock, so the capture lands on the chosen cycle. It then reads every bit back through the trigger clock. This is repeated with walking single hits and with pseudo-random eligibility patterns in both word lengths.

// File: rtl/trig_pkg.sv
package trig_pkg;

    localparam int unsigned MAX_CH = 64;

    typedef enum logic {
        LEN_FULL  = 1'b0,
        LEN_SHORT = 1'b1
    } len_sel_e;

    // ones in the low 'len' positions
    function automatic logic [MAX_CH-1:0] len_mask(input int unsigned len);
        logic [MAX_CH-1:0] m;
        m = '0;
        for (int unsigned i = 0; i < MAX_CH; i++) begin
            if (i < len) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/trig_hit_window.sv
module trig_hit_window #(
    parameter int unsigned N_CH       = 27,
    parameter int unsigned WIN_CYCLES = 9200
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] hit_i,
    input  logic [N_CH-1:0] elig_i,
    output logic [N_CH-1:0] flag_o
);
    localparam int unsigned CW = $clog2(WIN_CYCLES + 1);
    localparam logic [CW-1:0] WIN_LOAD = CW'(WIN_CYCLES);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } win_state_t;

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        win_state_t st_d, st_q;

        always_comb begin
            st_d = st_q;
            if (!elig_i[g]) begin
                st_d.cnt = '0;
            end else if (hit_i[g]) begin
                st_d.cnt = WIN_LOAD;
            end else if (st_q.cnt != '0) begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) st_q <= '0;
            else        st_q <= st_d;
        end

        assign flag_o[g] = (st_q.cnt != '0);
    end

endmodule

// File: rtl/trig_sync_edge.sv
module trig_sync_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    typedef struct packed {
        logic [STAGES-1:0] pipe;
        logic              prev;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pipe = {st_q.pipe[STAGES-2:0], async_i};
        st_d.prev = st_q.pipe[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = st_q.pipe[STAGES-1] & ~st_q.prev;

endmodule

// File: rtl/trig_shreg.sv
module trig_shreg
    import trig_pkg::*;
#(
    parameter int unsigned N_CH      = 27,
    parameter int unsigned SHORT_LEN = 18
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] flags_i,
    input  logic            lock_i,
    input  logic            shift_i,
    input  logic            short_i,
    output logic [N_CH-1:0] sr_o
);
    typedef struct packed {
        logic [N_CH-1:0] sr;
    } sh_state_t;

    sh_state_t       st_d, st_q;
    len_sel_e        len_sel;
    logic [N_CH-1:0] keep_mask;

    always_comb begin
        len_sel   = short_i ? LEN_SHORT : LEN_FULL;
        keep_mask = (len_sel == LEN_SHORT) ? N_CH'(len_mask(SHORT_LEN))
                                           : N_CH'(len_mask(N_CH));
        st_d = st_q;
        if (!lock_i) begin
            st_d.sr = flags_i & keep_mask;
        end else if (shift_i) begin
            st_d.sr = {1'b0, st_q.sr[N_CH-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sr_o = st_q.sr;

endmodule

// File: rtl/trig_word_shifter.sv
module trig_word_shifter #(
    parameter int unsigned N_CH        = 27,
    parameter int unsigned SHORT_LEN   = 18,
    parameter int unsigned WIN_CYCLES  = 9200,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] hit_i,
    input  logic [N_CH-1:0] anodic_i,
    input  logic [N_CH-1:0] auth_i,
    input  logic [N_CH-1:0] inhibit_i,
    input  logic            short_mode_i,
    input  logic            lock_i,
    input  logic            tclk_i,
    output logic            tdata_o
);
    logic [N_CH-1:0] elig;
    logic [N_CH-1:0] flags;
    logic [N_CH-1:0] sr_q;
    logic            shift_pulse;

    assign elig = anodic_i & auth_i & ~inhibit_i;

    trig_hit_window #(
        .N_CH       (N_CH),
        .WIN_CYCLES (WIN_CYCLES)
    ) u_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit_i  (hit_i),
        .elig_i (elig),
        .flag_o (flags)
    );

    trig_sync_edge #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (tclk_i),
        .rise_o  (shift_pulse)
    );

    trig_shreg #(
        .N_CH      (N_CH),
        .SHORT_LEN (SHORT_LEN)
    ) u_sr (
        .clk     (clk),
        .rst_n   (rst_n),
        .flags_i (flags),
        .lock_i  (lock_i),
        .shift_i (shift_pulse),
        .short_i (short_mode_i),
        .sr_o    (sr_q)
    );

    assign tdata_o = sr_q[0];

endmodule

// File: rtl/trig_word_chk.sv
module trig_word_chk #(
    parameter int unsigned N_CH      = 27,
    parameter int unsigned SHORT_LEN = 18
) (
    input logic            clk,
    input logic            rst_n,
    input logic            lock_i,
    input logic            short_mode_i,
    input logic            shift_pulse,
    input logic [N_CH-1:0] sr_q,
    input logic [N_CH-1:0] flags,
    input logic [N_CH-1:0] elig
);
    assert_locked_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_i && !shift_pulse) |=> $stable(sr_q));

    assert_shift_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_i && shift_pulse) |=> (sr_q == ($past(sr_q) >> 1)));

    assert_short_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (short_mode_i && !lock_i) |=> (sr_q[N_CH-1:SHORT_LEN] == '0));

    assert_inelig_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (elig != {N_CH{1'b1}}) |=> ((flags & ~$past(elig)) == '0));

endmodule

bind trig_word_shifter trig_word_chk #(
    .N_CH      (N_CH),
    .SHORT_LEN (SHORT_LEN)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lock_i       (lock_i),
    .short_mode_i (short_mode_i),
    .shift_pulse  (shift_pulse),
    .sr_q         (sr_q),
    .flags        (flags),
    .elig         (elig)
);

// File: tb/sim_trig_word_shifter.sv
module sim_trig_word_shifter;
    localparam int N   = 27;
    localparam int SL  = 18;
    localparam int WIN = 40;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] hit_i = '0, anodic_i = '1, auth_i = '1, inhibit_i = '0;
    logic         short_mode_i = 1'b0, lock_i = 1'b0, tclk_i = 1'b0;
    logic         tdata_o;

    int total = 0;
    int bad   = 0;
    logic [31:0] rng = 32'h1234_5678;

    always #2.5 clk = ~clk;

    trig_word_shifter #(.N_CH(N), .SHORT_LEN(SL), .WIN_CYCLES(WIN)) u0 (
        .clk(clk), .rst_n(rst_n), .hit_i(hit_i), .anodic_i(anodic_i),
        .auth_i(auth_i), .inhibit_i(inhibit_i), .short_mode_i(short_mode_i),
        .lock_i(lock_i), .tclk_i(tclk_i), .tdata_o(tdata_o));

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [63:0] lmask(input int len);
        return (64'd1 << len) - 64'd1;
    endfunction

    function automatic logic [31:0] nxt(input logic [31:0] x);
        logic [31:0] y = x;
        y = y ^ (y << 13); y = y ^ (y >> 17); y = y ^ (y << 5);
        return y;
    endfunction

    task automatic tpulse();
        tclk_i = 1'b1; step(4);
        tclk_i = 1'b0; step(4);
    endtask

    task automatic hit(input logic [N-1:0] v);
        hit_i = v; step(1); hit_i = '0;
    endtask

    // reads len+3 bits, so zero fill beyond the word is included
    task automatic read_word(input int len, output logic [63:0] w);
        w = '0;
        for (int i = 0; i < len + 3; i++) begin
            w[i] = tdata_o;
            tpulse();
        end
    endtask

    task automatic finish_case();
        lock_i = 1'b0; step(WIN + 2);
    endtask

    task automatic run_case(input string tag, input logic [N-1:0] v, input int d,
                            input logic [63:0] exp);
        logic [63:0] w;
        int len;
        len = short_mode_i ? SL : N;
        hit(v); step(d); lock_i = 1'b1;
        read_word(len, w);
        chk(tag, w, exp);
        finish_case();
    endtask

    initial begin
        logic [63:0] w;
        logic [N-1:0] e;
        step(3); rst_n = 1'b1; step(2);

        // R1 reset state
        chk("R1 out after reset", 64'(tdata_o), 64'd0);
        lock_i = 1'b1; read_word(N, w); chk("R1 empty word", w, 64'd0);
        finish_case();

        // R4 R7 R9: walking hit, full length
        for (int c = 0; c < N; c++)
            run_case("R4/R7/R9 walk full", N'(1) << c, 2, 64'd1 << c);

        // R8: walking hit, short length
        short_mode_i = 1'b1;
        for (int c = 0; c < N; c++)
            run_case("R8 walk short", N'(1) << c, 2,
                     (c < SL) ? (64'd1 << c) : 64'd0);
        short_mode_i = 1'b0;

        // R4 eligibility sweep in both lengths
        for (int k = 0; k < 12; k++) begin
            logic [N-1:0] hv;
            rng = nxt(rng); anodic_i  = N'(rng);
            rng = nxt(rng); auth_i    = N'(rng);
            rng = nxt(rng); inhibit_i = N'(rng) & N'(rng >> 3);
            rng = nxt(rng); hv        = N'(rng) | N'(rng >> 5);
            short_mode_i = k[0];
            e = hv & anodic_i & auth_i & ~inhibit_i;
            run_case("R4 eligibility", hv, 3,
                     64'(e) & lmask(k[0] ? SL : N));
        end
        anodic_i = '1; auth_i = '1; inhibit_i = '0; short_mode_i = 1'b0;

        // R2 window boundary
        run_case("R2 last valid cycle", N'(1) << 4, WIN, 64'd1 << 4);
        run_case("R2 expired", N'(1) << 4, WIN + 1, 64'd0);

        // R3 retrigger restarts window
        hit(N'(1) << 3); step(WIN - 5);
        run_case("R3 retrigger still valid", N'(1) << 3, WIN, 64'd1 << 3);
        hit(N'(1) << 3); step(WIN - 5);
        run_case("R3 retrigger expires", N'(1) << 3, WIN + 1, 64'd0);

        // R5 inhibit during the window clears the flag
        hit((N'(1) << 5) | (N'(1) << 7)); step(3);
        inhibit_i[5] = 1'b1; step(2); inhibit_i = '0; step(1);
        lock_i = 1'b1; read_word(N, w);
        chk("R5 inhibit mid-window", w, 64'd1 << 7);
        finish_case();

        // R6 freeze while locked
        hit(N'(1) << 1 | N'(1) << 9); step(2); lock_i = 1'b1;
        hit(N'(1) << 2 | N'(1) << 20); step(5);
        read_word(N, w);
        chk("R6 locked word frozen", w, (64'd1 << 1) | (64'd1 << 9));
        finish_case();

        // R10 trigger clock with lock low
        hit(N'(1) << 0 | N'(1) << 6); tpulse(); tpulse(); lock_i = 1'b1;
        read_word(N, w);
        chk("R10 edges unlocked ignored", w, 64'd1 | (64'd1 << 6));
        finish_case();

        // R7 shift latency
        hit(N'(1) << 0); step(2); lock_i = 1'b1;
        chk("R7 bit0 present", 64'(tdata_o), 64'd1);
        tclk_i = 1'b1; step(2);
        chk("R7 not yet shifted", 64'(tdata_o), 64'd1);
        step(1);
        chk("R7 shifted on third edge", 64'(tdata_o), 64'd0);
        tclk_i = 1'b0; step(4);
        finish_case();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule